// File: doc/BRIEF.md
# Programmable LED Blinker with Auto-Stop

This block drives one LED line with a periodic on/off pattern. A prescaler turns the core clock into a slower tick whose spacing is a power of two clock cycles. A period counter advances once per tick. The LED is lit while that counter sits below a programmed duty value. The counter returns to zero after it reaches the programmed period value.

Software programs the blinker through four word registers on a simple write port, and reads them back through a combinational read port. The control register holds the divider select, an enable, an auto-stop enable and an interrupt mask. With auto-stop set, the block counts finished blink periods. After the programmed number of periods it switches itself off by clearing its own enable bit. It then raises a one-cycle completion interrupt unless the mask bit is set.

Top module: `led_blink`

## Requirements
- R1: After reset every register reads 0, `led_o` is low and `irq_o` is low.
- R2: `addr` selects a register: 0 is control (7 bits), 1 is period (12 bits), 2 is duty (12 bits), 3 is stop count (16 bits). A write stores the low bits of `wr_data`, and `rd_data` returns the stored value zero-extended.
- R3: Control bits [3:0] give the select n. While enabled, the period counter advances once every 2^n clock cycles.
- R4: A select of 14 or 15 behaves exactly as 13.
- R5: The period counter runs from 0 to the period value and then returns to 0, so one blink lasts period+1 ticks. `led_o` is high while the counter is below the duty value. A duty value above the period keeps the LED lit.
- R6: While control bit 4 (enable) is 0, `led_o` is low and the prescaler and period counter are held at zero.
- R7: With control bit 5 (auto-stop) set, the block clears control bit 4 on the clock edge that ends the last counted blink. The number of blinks is the stop count, and a stop count of 0 acts as 1. `led_o` is low from that edge on.
- R8: The remaining blink count is reloaded from the stop-count register on every write to the control register, and from `wr_data` on every write to the stop-count register.
- R9: `irq_o` is high for the single clock cycle after an auto-stop edge when control bit 6 (mask) was 0. With the mask set it stays low.
- R10: A write to the control register in the same cycle as an auto-stop stores the written value. The interrupt for that stop is still raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| led_o | output | 1 | LED drive, high means lit |
| irq_o | output | 1 | Auto-stop completion pulse |

## Verification
The risky coincidence is a software write to the control register landing in the same cycle as the auto-stop clear of the enable bit. The bench predicts the cycle of the final blink edge from its own model and issues the control write exactly there. It then judges the result by reading back the written value with the enable bit still set, and by seeing the interrupt pulse anyway. A reload of the remaining count in that same cycle must also start the next auto-stop run from the full count. The random phase keeps checking this every cycle against the model.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    localparam int DATA_W      = 16;
    localparam int CTRL_W      = 7;
    localparam int PER_W       = 12;
    localparam int CNT_W       = 16;
    localparam int DIV_LOG_MAX = 13;
    localparam int DIV_SEL_W   = 4;

    // control register bit positions
    localparam int EN_BIT   = 4;
    localparam int AUTO_BIT = 5;
    localparam int MASK_BIT = 6;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_PERIOD  = 2'd1,
        SEL_DUTY    = 2'd2,
        SEL_STOPCNT = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/lb_regs.sv
module lb_regs
    import led_blink_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = CTRL_W,
    parameter int PW = PER_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          stop_i,
    output logic [DW-1:0] rd_data_o,
    output logic [TW-1:0] ctrl_o,
    output logic [PW-1:0] per_o,
    output logic [PW-1:0] duty_o,
    output logic          reload_o,
    output logic [CW-1:0] reload_val_o
);

    typedef struct packed {
        logic [TW-1:0] ctrl;
        logic [PW-1:0] per;
        logic [PW-1:0] duty;
        logic [CW-1:0] cnt;
    } regs_t;

    regs_t    regs_q, regs_d;
    reg_sel_e sel;
    logic     ctrl_wr;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        regs_d  = regs_q;
        ctrl_wr = wr_en_i && (sel == SEL_CTRL);
        // auto-stop clear first, so that a software write in the same cycle wins
        if (stop_i) begin
            regs_d.ctrl[EN_BIT] = 1'b0;
        end
        if (wr_en_i) begin
            unique case (sel)
                SEL_CTRL:    regs_d.ctrl = wr_data_i[TW-1:0];
                SEL_PERIOD:  regs_d.per  = wr_data_i[PW-1:0];
                SEL_DUTY:    regs_d.duty = wr_data_i[PW-1:0];
                SEL_STOPCNT: regs_d.cnt  = wr_data_i[CW-1:0];
                default:     regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (sel)
            SEL_CTRL:    rd_data_o[TW-1:0] = regs_q.ctrl;
            SEL_PERIOD:  rd_data_o[PW-1:0] = regs_q.per;
            SEL_DUTY:    rd_data_o[PW-1:0] = regs_q.duty;
            SEL_STOPCNT: rd_data_o[CW-1:0] = regs_q.cnt;
            default:     rd_data_o = '0;
        endcase
    end

    assign ctrl_o       = regs_q.ctrl;
    assign per_o        = regs_q.per;
    assign duty_o       = regs_q.duty;
    assign reload_o     = wr_en_i && ((sel == SEL_CTRL) || (sel == SEL_STOPCNT));
    assign reload_val_o = (sel == SEL_STOPCNT) ? wr_data_i[CW-1:0] : regs_q.cnt;

    // R7: an auto-stop without a competing control write leaves the enable cleared
    assert_stop_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !(wr_en_i && sel == SEL_CTRL)) |=> !regs_q.ctrl[EN_BIT]);

    // R10: a control write that meets an auto-stop is stored unchanged
    assert_write_beats_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && wr_en_i && sel == SEL_CTRL) |=> (regs_q.ctrl == $past(wr_data_i[TW-1:0])));

endmodule

// File: rtl/lb_prescaler.sv
module lb_prescaler
    import led_blink_pkg::*;
#(
    parameter int LOGMAX = DIV_LOG_MAX,
    parameter int SW     = DIV_SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [SW-1:0] sel_i,
    output logic          tick_o
);

    localparam logic [SW-1:0] SEL_CAP = SW'(LOGMAX);

    typedef struct packed {
        logic [LOGMAX-1:0] cnt;
    } pre_t;

    pre_t              pre_q, pre_d;
    logic [SW-1:0]     n_eff;
    logic [LOGMAX-1:0] limit;

    always_comb begin
        n_eff = (sel_i > SEL_CAP) ? SEL_CAP : sel_i;
        for (int i = 0; i < LOGMAX; i++) begin
            limit[i] = (i < int'(n_eff));
        end
        // >= keeps the spacing bounded when the select shrinks mid-count
        tick_o = en_i && (pre_q.cnt >= limit);
        pre_d  = pre_q;
        if (!en_i || tick_o) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R3: between ticks the prescaler advances by exactly one per cycle
    assert_prescale_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_o) |=> (pre_q.cnt == $past(pre_q.cnt) + 1'b1));

    // R6: a disabled blinker leaves the prescaler at zero
    assert_prescale_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pre_q.cnt == '0));

endmodule

// File: rtl/lb_wave.sv
module lb_wave
    import led_blink_pkg::*;
#(
    parameter int PW = PER_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          auto_i,
    input  logic          mask_i,
    input  logic          tick_i,
    input  logic [PW-1:0] per_i,
    input  logic [PW-1:0] duty_i,
    input  logic          reload_i,
    input  logic [CW-1:0] reload_val_i,
    output logic          stop_o,
    output logic          led_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [PW-1:0] pcnt;
        logic [CW-1:0] remain;
        logic          irq;
    } wave_t;

    wave_t wave_q, wave_d;
    logic  wrap;

    always_comb begin
        wave_d = wave_q;
        wrap   = tick_i && (wave_q.pcnt >= per_i);
        stop_o = wrap && auto_i && (wave_q.remain <= CW'(1));

        if (!en_i) begin
            wave_d.pcnt = '0;
        end else if (tick_i) begin
            wave_d.pcnt = wrap ? '0 : wave_q.pcnt + 1'b1;
        end

        if (reload_i) begin
            wave_d.remain = reload_val_i;
        end else if (wrap && auto_i && !stop_o) begin
            wave_d.remain = wave_q.remain - 1'b1;
        end

        wave_d.irq = stop_o && !mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= '0;
        end else begin
            wave_q <= wave_d;
        end
    end

    assign led_o = en_i && (wave_q.pcnt < duty_i);
    assign irq_o = wave_q.irq;

    // R5: the period counter moves only on a prescaler tick
    assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(wave_q.pcnt));

    // R6: a disabled blinker keeps its period counter at zero
    assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (wave_q.pcnt == '0));

    // R9: a completion pulse needs auto-stop on and the mask off one cycle before
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(auto_i) && !$past(mask_i)));

endmodule

// File: rtl/led_blink.sv
module led_blink
    import led_blink_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int PW     = PER_W,
    parameter int CW     = CNT_W,
    parameter int LOGMAX = DIV_LOG_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          led_o,
    output logic          irq_o
);

    logic [CTRL_W-1:0] ctrl;
    logic [PW-1:0]     per;
    logic [PW-1:0]     duty;
    logic              reload;
    logic [CW-1:0]     reload_val;
    logic              tick;
    logic              stop;

    lb_regs #(.DW(DW), .TW(CTRL_W), .PW(PW), .CW(CW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .addr_i       (addr),
        .wr_data_i    (wr_data),
        .stop_i       (stop),
        .rd_data_o    (rd_data),
        .ctrl_o       (ctrl),
        .per_o        (per),
        .duty_o       (duty),
        .reload_o     (reload),
        .reload_val_o (reload_val)
    );

    lb_prescaler #(.LOGMAX(LOGMAX), .SW(DIV_SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl[EN_BIT]),
        .sel_i  (ctrl[DIV_SEL_W-1:0]),
        .tick_o (tick)
    );

    lb_wave #(.PW(PW), .CW(CW)) u_wave (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (ctrl[EN_BIT]),
        .auto_i       (ctrl[AUTO_BIT]),
        .mask_i       (ctrl[MASK_BIT]),
        .tick_i       (tick),
        .per_i        (per),
        .duty_i       (duty),
        .reload_i     (reload),
        .reload_val_i (reload_val),
        .stop_o       (stop),
        .led_o        (led_o),
        .irq_o        (irq_o)
    );

endmodule

// File: tb/tb_led_blink.sv
module tb_led_blink;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  addr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        led_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model state
    logic [6:0]  m_ctrl;
    logic [11:0] m_per, m_duty;
    logic [15:0] m_cnt, m_rem;
    logic [12:0] m_div;
    logic [11:0] m_pc;
    logic        m_irq;

    always #2 clk = ~clk;

    led_blink dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .led_o(led_o), .irq_o(irq_o)
    );

    function automatic logic [12:0] m_limit(input logic [3:0] sel);
        int n;
        n = (sel > 4'd13) ? 13 : int'(sel);
        return 13'((1 << n) - 1);
    endfunction

    function automatic logic m_stop_now();
        logic tk, wr;
        tk = m_ctrl[4] && (m_div >= m_limit(m_ctrl[3:0]));
        wr = tk && (m_pc >= m_per);
        return wr && m_ctrl[5] && (m_rem <= 16'd1);
    endfunction

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {9'd0, m_ctrl};
            2'd1:    return {4'd0, m_per};
            2'd2:    return {4'd0, m_duty};
            default: return m_cnt;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic we, input logic [1:0] a, input logic [15:0] d);
        logic        tk, wr, st;
        logic [12:0] div_n;
        logic [11:0] pc_n;
        logic [15:0] rem_n;
        logic [6:0]  ctrl_n;
        tk = m_ctrl[4] && (m_div >= m_limit(m_ctrl[3:0]));
        wr = tk && (m_pc >= m_per);
        st = wr && m_ctrl[5] && (m_rem <= 16'd1);
        div_n = (!m_ctrl[4] || tk) ? 13'd0 : m_div + 13'd1;
        pc_n  = !m_ctrl[4] ? 12'd0 : (tk ? (wr ? 12'd0 : m_pc + 12'd1) : m_pc);
        rem_n = m_rem;
        if (we && (a == 2'd0 || a == 2'd3)) rem_n = (a == 2'd3) ? d : m_cnt;
        else if (wr && m_ctrl[5] && !st) rem_n = m_rem - 16'd1;
        ctrl_n = m_ctrl;
        if (st) ctrl_n[4] = 1'b0;
        if (we && a == 2'd0) ctrl_n = d[6:0];
        if (we && a == 2'd1) m_per  = d[11:0];
        if (we && a == 2'd2) m_duty = d[11:0];
        if (we && a == 2'd3) m_cnt  = d;
        m_irq  = st && !m_ctrl[6];
        m_ctrl = ctrl_n;
        m_div  = div_n;
        m_pc   = pc_n;
        m_rem  = rem_n;
    endtask

    // one clock: drive, advance the model, sample after the edge
    task automatic cycle(input logic we, input logic [1:0] a, input logic [15:0] d, input string tag);
        wr_en = we; addr = a; wr_data = d;
        model_step(we, a, d);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " led"}, 32'(led_o), 32'(m_ctrl[4] && (m_pc < m_duty)));
        chk({tag, " irq"}, 32'(irq_o), 32'(m_irq));
        chk({tag, " rd"},  32'(rd_data), 32'(m_read(a)));
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 16'd0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
        cycle(1'b1, a, d, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int irq_seen, lit, hit;
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 16'd0;
        m_ctrl = '0; m_per = '0; m_duty = '0; m_cnt = '0; m_rem = '0;
        m_div = '0; m_pc = '0; m_irq = 1'b0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 led", 32'(led_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a); #1;
            chk("R1 rd", 32'(rd_data), 0);
        end
        rst_n = 1'b1;

        // R2: register widths and readback
        wr(2'd1, 16'hFFFF, "R2");
        wr(2'd2, 16'hFFFF, "R2");
        wr(2'd3, 16'hFFFF, "R2");
        wr(2'd0, 16'hFF80, "R2");
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a); #1;
            chk("R2 width", 32'(rd_data), (a == 0) ? 0 : (a == 3) ? 32'hFFFF : 32'hFFF);
        end

        // R5: normal blink, then duty above period
        wr(2'd1, 16'd4, "R5"); wr(2'd2, 16'd2, "R5");
        wr(2'd0, 16'h0011, "R5"); idle(40, "R5");
        wr(2'd0, 16'h0000, "R5");
        wr(2'd1, 16'd3, "R5"); wr(2'd2, 16'd7, "R5");
        wr(2'd0, 16'h0012, "R5"); idle(30, "R5");

        // R3: slower time base
        wr(2'd0, 16'h0000, "R3");
        wr(2'd1, 16'd1, "R3"); wr(2'd2, 16'd1, "R3");
        wr(2'd0, 16'h0013, "R3"); idle(64, "R3");

        // R4: select 15 clamps to 13: lit for 8192 of 16384 cycles
        wr(2'd0, 16'h0000, "R4");
        wr(2'd0, 16'h001F, "R4");
        lit = 0;
        for (int i = 0; i < 16384; i++) begin
            cycle(1'b0, 2'd0, 16'd0, "R4");
            if (led_o) lit++;
        end
        chk("R4 lit count", 32'(lit), 8192);

        // R6: disable mid-blink
        wr(2'd0, 16'h0010, "R6"); idle(5, "R6");
        wr(2'd0, 16'h0000, "R6"); idle(10, "R6");
        chk("R6 led off", 32'(led_o), 0);

        // R7/R9: three blinks then stop with interrupt
        wr(2'd1, 16'd2, "R7"); wr(2'd2, 16'd1, "R7"); wr(2'd3, 16'd3, "R7");
        wr(2'd0, 16'h0030, "R7");
        irq_seen = 0;
        for (int i = 0; i < 20; i++) begin
            cycle(1'b0, 2'd0, 16'd0, "R7");
            if (irq_o) irq_seen++;
        end
        chk("R9 one pulse", 32'(irq_seen), 1);
        addr = 2'd0; #1;
        chk("R7 enable cleared", 32'(rd_data[4]), 0);

        // R9: masked stop gives no pulse
        wr(2'd0, 16'h0070, "R9");
        irq_seen = 0;
        for (int i = 0; i < 20; i++) begin
            cycle(1'b0, 2'd0, 16'd0, "R9");
            if (irq_o) irq_seen++;
        end
        chk("R9 masked", 32'(irq_seen), 0);

        // R8: count 0 acts as 1, and a count rewrite mid-run reloads
        wr(2'd3, 16'd0, "R8"); wr(2'd0, 16'h0030, "R8"); idle(8, "R8");
        wr(2'd3, 16'd5, "R8"); wr(2'd0, 16'h0030, "R8"); idle(6, "R8");
        wr(2'd3, 16'd1, "R8"); idle(12, "R8");

        // R10: control write in the auto-stop cycle
        wr(2'd1, 16'd0, "R10"); wr(2'd3, 16'd2, "R10");
        wr(2'd0, 16'h0030, "R10");
        hit = 0;
        for (int i = 0; i < 50 && hit == 0; i++) begin
            if (m_stop_now()) begin
                wr(2'd0, 16'h0030, "R10");
                hit = 1;
                chk("R10 write kept", 32'(rd_data), 32'h30);
                chk("R10 irq raised", 32'(irq_o), 1);
            end else begin
                cycle(1'b0, 2'd0, 16'd0, "R10");
            end
        end
        chk("R10 collision reached", 32'(hit), 1);
        idle(10, "R10");

        // random mix, checked every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  ra;
            logic [15:0] rd;
            ra = 2'($urandom_range(0, 3));
            case (ra)
                2'd0:    rd = 16'($urandom_range(0, 127)) & 16'h0073;
                2'd1:    rd = 16'($urandom_range(0, 6));
                2'd2:    rd = 16'($urandom_range(0, 8));
                default: rd = 16'($urandom_range(0, 3));
            endcase
            if ($urandom_range(0, 15) == 0) cycle(1'b1, ra, rd, "R5 random");
            else cycle(1'b0, ra, 16'd0, "R7 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule